// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the hardware side of a circular receive-descriptor ring held in a word-addressed memory. Each descriptor takes four consecutive 32-bit words. Word 0 is the link to the next descriptor. Word 1 is command/status. Word 2 is the buffer address. Word 3 is left to software. Links and buffer addresses are word addresses in the low `AW` bits. Software builds the ring in memory, writes the address of the first descriptor into the pointer input and issues a start command. The engine then reads the descriptor and waits for a frame.

Frame bytes arrive on a byte stream that has no back-pressure. The stream carries a last-byte flag and an error flag. The engine packs the bytes little-endian into the buffer. When the frame ends, it writes back the command/status word with the received length (CRC included), the result bits and the ownership bit. Setting the ownership bit hands the descriptor back to the host. The engine then follows the link.

If the next descriptor is still owned by the host, the engine goes idle until a new start command arrives, and that command makes it re-read the same descriptor. Frames that begin while the engine cannot take them are dropped and counted.

Memory timing is fixed. The memory samples the request on a clock edge. Read data is valid from that edge until the next one.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the engine is stopped: no memory request is issued, the missed-frame count is 0, and no fetch occurs until a start command.
- R2: A start command (control bit 2) reads the current descriptor's words at offsets 0, 1 and 2, in that order.
- R3: Frame byte i is written into buffer word (buffer address + i/4) at bits 8*(i%4)+7 down to 8*(i%4). A final word that is not full is written with its unused upper bytes set to zero.
- R4: After the last data write of a frame, the status word is written to descriptor offset 1. In it, bit 31 (ownership) is 1, bit 29 (interrupt request) is copied from the fetched command word, bit 27 (packet OK) is 1 for a clean frame, and bits 11:0 hold the byte count including the 4 CRC bytes. Bits 30 and 28 are written as 0.
- R5: A frame with the error flag set on any of its bytes gets packet OK (bit 27) cleared.
- R6: A frame longer than the capacity (bits 11:0 of the fetched command word) stores only capacity bytes and writes no word beyond them. Its status has bit 22 (too long) set, bit 27 clear, and the full byte count.
- R7: After the status write, the engine fetches the descriptor named by the link word, so the ring wraps from the last descriptor to the first.
- R8: If the fetched command word has bit 31 set, the engine goes idle and writes nothing. Frames starting while idle are dropped and counted. A new start command re-reads the same descriptor.
- R9: A stop command (control bit 3) halts the engine. Frames starting while it is stopped are dropped and counted, and nothing is written.
- R10: The missed-frame count increments once per dropped frame and saturates at its maximum value (255 at the default width).
- R11: A receive-reset command (control bit 5) stops the engine, clears the missed-frame count and sets the current descriptor address to 0.
- R12: A pointer write while the engine is stopped or idle sets the current descriptor address used by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control command strobe |
| ctl_wdata | input | 32 | Command bits: 2 start, 3 stop, 5 receive reset |
| ptr_wr | input | 1 | Descriptor pointer write strobe |
| ptr_wdata | input | AW | Word address of the current descriptor |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of the frame |
| rx_err | input | 1 | Frame error flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after the request |
| missed_count | output | MW | Saturating count of dropped frames |

## Verification
A buffer word appears on the memory port in the cycle after the edge that accepts its fourth byte, its last byte, or its capacity-limit byte. The status write appears exactly one cycle after that. The first descriptor read appears one cycle after the start command is sampled, and the engine accepts frames five edges after that command.

The bench predicts every write as an address/data pair from the requirements, in order. It compares each write on the falling edge while the write is on the port, and it logs every read address for the fetch-order checks. The bench waits a margin of cycles after each start command and after each frame, so that frames never start inside a fetch. The missed-frame count settles one edge after a frame starts, and it is checked only once the stimulus has been quiet for several cycles.

// File: rtl/rxr_pkg.sv
// Package rxr_pkg
// Shared state type and bit positions for the receive ring writer.
// Assumes 32-bit descriptor words and 12-bit size fields.
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_FETCH,
        ST_READY,
        ST_RECV,
        ST_WBACK
    } rxr_state_e;

    localparam int SIZE_W    = 12;
    localparam int BIT_OWN   = 31;
    localparam int BIT_MORE  = 30;
    localparam int BIT_INTR  = 29;
    localparam int BIT_NOCRC = 28;
    localparam int BIT_OK    = 27;
    localparam int BIT_LONG  = 22;
    localparam int CTL_ON    = 2;
    localparam int CTL_OFF   = 3;
    localparam int CTL_RST   = 5;
    localparam int FETCH_LAST_STEP = 4;
endpackage

// File: rtl/rxr_frame_tracker.sv
// Module rxr_frame_tracker
// Flags the first byte of each frame on the byte stream.
// Assumes every frame ends with a byte that has rx_last set.
module rxr_frame_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_last,
    output logic frame_start
);
    logic in_frame;

    // Remember whether a frame is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) in_frame <= 1'b0;
        else if (rx_valid) in_frame <= !rx_last;
    end

    assign frame_start = rx_valid && !in_frame;
endmodule

// File: rtl/rxr_byte_packer.sv
// Module rxr_byte_packer
// Assembles stored bytes into little-endian 32-bit words and emits a
// word when its lane 3, the frame end or the capacity limit is reached.
// Assumes the caller presents a byte's lane from its byte index.
module rxr_byte_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        store,
    input  logic        flush,
    input  logic [1:0]  lane,
    input  logic [7:0]  byte_in,
    output logic        emit,
    output logic [31:0] word
);
    logic [31:0] wbuf;
    logic [31:0] wbase;

    // Merge the incoming byte into the partially filled word.
    always_comb begin
        wbase = clr ? 32'd0 : wbuf;
        word  = wbase | (32'(byte_in) << (8 * lane));
        emit  = store && flush;
    end

    // Hold the partial word, emptying it after each emitted word.
    always_ff @(posedge clk) begin
        if (!rst_n) wbuf <= 32'd0;
        else if (emit) wbuf <= 32'd0;
        else if (store) wbuf <= word;
        else if (clr) wbuf <= 32'd0;
    end
endmodule

// File: rtl/rxr_sat_counter.sv
// Module rxr_sat_counter
// Counter that sticks at its maximum value; clear has priority over
// increment.
module rxr_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;

    // Count events up to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (clr) count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end

    assert_missed_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && !clr) |=> (count == MAXV));
    assert_missed_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));
endmodule

// File: rtl/rx_ring_writer.sv
// Module rx_ring_writer
// Walks a circular receive-descriptor ring: fetches link, command and
// buffer words, stores frame bytes into the buffer, writes back status
// with ownership set, then follows the link.
// Assumes a memory that samples requests on the edge and returns read
// data valid in the following cycle, and a stream with no back-pressure.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW = 12,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [31:0]   ctl_wdata,
    input  logic          ptr_wr,
    input  logic [AW-1:0] ptr_wdata,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [MW-1:0] missed_count
);
    localparam logic [SIZE_W-1:0] CNT_MAX = '1;

    rxr_state_e        state;
    logic [2:0]        fstep;
    logic [AW-1:0]     cur, link_r, buf_r;
    logic [SIZE_W-1:0] cap_r, cnt;
    logic              intr_r, own_r, err_r, long_r;
    logic              c_rst, c_off, c_on, stop_cmd;
    logic              start, take, store, flush, miss_inc;
    logic              pk_emit;
    logic [31:0]       pk_word, status_w;

    wire unused_rdata = ^mem_rdata;
    wire unused_ctl   = ^ctl_wdata;

    rxr_frame_tracker u_track (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
        .frame_start(start)
    );

    // Decode commands by priority and decide what happens to this byte.
    always_comb begin
        c_rst    = ctl_wr && ctl_wdata[CTL_RST];
        c_off    = ctl_wr && ctl_wdata[CTL_OFF] && !c_rst;
        c_on     = ctl_wr && ctl_wdata[CTL_ON] && !c_rst && !c_off;
        stop_cmd = c_rst || c_off;
        take     = rx_valid && !stop_cmd &&
                   ((state == ST_READY && start) || state == ST_RECV);
        miss_inc = start && !(state == ST_READY && !stop_cmd);
        store    = take && (cnt < cap_r);
        flush    = (cnt[1:0] == 2'd3) || rx_last || (cnt == cap_r - 1'b1);
    end

    rxr_byte_packer u_pack (
        .clk(clk), .rst_n(rst_n), .clr(start), .store(store), .flush(flush),
        .lane(cnt[1:0]), .byte_in(rx_data), .emit(pk_emit), .word(pk_word)
    );

    rxr_sat_counter #(.W(MW)) u_missed (
        .clk(clk), .rst_n(rst_n), .clr(c_rst), .inc(miss_inc),
        .count(missed_count)
    );

    // Form the write-back status word from the frame outcome.
    always_comb begin
        status_w              = 32'd0;
        status_w[BIT_OWN]     = 1'b1;
        status_w[BIT_MORE]    = 1'b0;
        status_w[BIT_INTR]    = intr_r;
        status_w[BIT_NOCRC]   = 1'b0;
        status_w[BIT_OK]      = !err_r && !long_r;
        status_w[BIT_LONG]    = long_r;
        status_w[SIZE_W-1:0]  = cnt;
    end

    // Sequence fetches, byte storage and status write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;  fstep <= '0;
            cur <= '0;  link_r <= '0;  buf_r <= '0;
            cap_r <= '0;  cnt <= '0;
            intr_r <= 1'b0;  own_r <= 1'b0;  err_r <= 1'b0;  long_r <= 1'b0;
            mem_req <= 1'b0;  mem_we <= 1'b0;  mem_addr <= '0;  mem_wdata <= '0;
        end else begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (take) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                if (rx_err) err_r <= 1'b1;
                if (cnt >= cap_r) long_r <= 1'b1;
            end
            if (pk_emit) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= buf_r + AW'(cnt >> 2);
                mem_wdata <= pk_word;
            end
            if (c_rst) begin
                state <= ST_OFF;
                cur   <= '0;
            end else if (c_off) begin
                state <= ST_OFF;
            end else begin
                unique case (state)
                    ST_OFF, ST_IDLE: begin
                        if (ptr_wr) cur <= ptr_wdata;
                        if (c_on) begin
                            state <= ST_FETCH;
                            fstep <= '0;
                        end
                    end
                    ST_FETCH: begin
                        fstep <= fstep + 1'b1;
                        if (fstep < 3'd3) begin
                            mem_req  <= 1'b1;
                            mem_addr <= cur + AW'(fstep);
                        end
                        if (fstep == 3'd2) link_r <= mem_rdata[AW-1:0];
                        if (fstep == 3'd3) begin
                            cap_r  <= mem_rdata[SIZE_W-1:0];
                            intr_r <= mem_rdata[BIT_INTR];
                            own_r  <= mem_rdata[BIT_OWN];
                        end
                        if (fstep == 3'(FETCH_LAST_STEP)) begin
                            buf_r  <= mem_rdata[AW-1:0];
                            cnt    <= '0;
                            err_r  <= 1'b0;
                            long_r <= 1'b0;
                            state  <= own_r ? ST_IDLE : ST_READY;
                        end
                    end
                    ST_READY: if (take) state <= rx_last ? ST_WBACK : ST_RECV;
                    ST_RECV:  if (take && rx_last) state <= ST_WBACK;
                    ST_WBACK: begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b1;
                        mem_addr  <= cur + AW'(1);
                        mem_wdata <= status_w;
                        cur       <= link_r;
                        state     <= ST_FETCH;
                        fstep     <= '0;
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    logic [AW-1:0] chk_off;
    logic [12:0]   chk_capw;
    always_comb begin
        chk_off  = mem_addr - buf_r;
        chk_capw = (13'(cap_r) + 13'd3) >> 2;
    end

    assert_no_read_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV) |-> !(mem_req && !mem_we));
    assert_data_within_capacity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && mem_req && mem_we) |-> (int'(chk_off) < int'(chk_capw)));
    assert_status_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBACK && !stop_cmd) |=> (mem_req && mem_we && mem_wdata[BIT_OWN]
                                              && state == ST_FETCH));
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_req);
endmodule

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
    localparam int AW = 12;
    localparam int MW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [31:0]   ctl_wdata = '0;
    logic          ptr_wr = 1'b0;
    logic [AW-1:0] ptr_wdata = '0;
    logic          rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic [MW-1:0] missed_count;

    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_data = '0;
    logic [31:0]   mem [0:(1<<AW)-1];

    int nchk = 0, nerr = 0;
    bit done = 0;
    int          ea[$];
    logic [31:0] ed[$];
    string       etag[$];
    int          rd_log[$];

    always #2.5 clk = ~clk;

    rx_ring_writer #(.AW(AW), .MW(MW)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .missed_count(missed_count)
    );

    // Behavioural memory with the host's own write port.
    always @(posedge clk) begin
        if (host_wr) mem[host_addr] <= host_data;
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare each write against the predicted sequence; log reads.
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                if (ea.size() == 0) begin
                    check(0, "R8", "unexpected write addr", longint'(mem_addr), -1);
                end else begin
                    automatic int a = ea.pop_front();
                    automatic logic [31:0] d = ed.pop_front();
                    automatic string t = etag.pop_front();
                    check(mem_addr == AW'(a), t, "write address", longint'(mem_addr), longint'(a));
                    check(mem_wdata == d, t, "write data", longint'(mem_wdata), longint'(d));
                end
            end else begin
                rd_log.push_back(int'(mem_addr));
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = AW'(a); host_data = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic ctl(input logic [31:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic set_ptr(input int a);
        @(negedge clk); ptr_wr = 1'b1; ptr_wdata = AW'(a);
        @(negedge clk); ptr_wr = 1'b0;
    endtask

    task automatic send_frame(input int len, input int seed, input bit err);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'((seed + k) & 255);
            rx_last  = (k == len - 1);
            rx_err   = err && (k == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    // Predict the buffer writes and the status write of one frame.
    task automatic expect_frame(input int desc, input int bufa, input int cap,
                                input int len, input int seed, input bit err,
                                input bit intr, input string dtag, input string stag);
        automatic logic [31:0] w = '0;
        automatic int stored = (len < cap) ? len : cap;
        automatic logic [31:0] st;
        for (int i = 0; i < stored; i++) begin
            w |= 32'((seed + i) & 255) << (8 * (i % 4));
            if (i % 4 == 3 || i == len - 1 || i == cap - 1) begin
                ea.push_back(bufa + i / 4); ed.push_back(w); etag.push_back(dtag);
                w = '0;
            end
        end
        st = 32'h8000_0000 | (32'(intr) << 29) | (32'(!err && len <= cap) << 27)
           | (32'(len > cap) << 22) | 32'(len & 12'hFFF);
        ea.push_back(desc + 1); ed.push_back(st); etag.push_back(stag);
    endtask

    task automatic check_reads(input int base, input string tag);
        check(rd_log.size() >= 3, tag, "fetch read count", rd_log.size(), 3);
        for (int i = 0; i < 3; i++)
            if (rd_log.size() > i)
                check(rd_log[i] == base + i, tag, "fetch read address", rd_log[i], base + i);
    endtask

    task automatic check_drained(input string tag);
        check(ea.size() == 0, tag, "pending expected writes", ea.size(), 0);
    endtask

    // Watchdog: an unfinished run is a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog (all R): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        cycles(4);
        check(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
        rst_n = 1'b1;
        cycles(6);
        check(missed_count == 0, "R1", "missed after reset", missed_count, 0);
        check(rd_log.size() == 0, "R1", "reads before start", rd_log.size(), 0);

        // Build the ring: four descriptors at 0,4,8,12; the last one is small.
        for (int i = 0; i < 4; i++) begin
            host_write(4 * i,     32'(4 * ((i + 1) % 4)));
            host_write(4 * i + 1, (i == 3) ? 32'd10 : ((i == 1) ? 32'h2000_0600 : 32'd1536));
            host_write(4 * i + 2, 32'(64 + 384 * i));
        end
        set_ptr(0);
        ctl(32'h4);
        cycles(10);
        check_reads(0, "R2");

        expect_frame(0, 64, 1536, 64, 8'h10, 0, 0, "R3", "R4");
        send_frame(64, 8'h10, 0);
        cycles(15); check_drained("R4");

        expect_frame(4, 448, 1536, 61, 8'h55, 1, 1, "R3", "R5");
        send_frame(61, 8'h55, 1);
        cycles(15); check_drained("R5");

        expect_frame(8, 832, 1536, 1, 8'hA7, 0, 0, "R3", "R4");
        send_frame(1, 8'hA7, 0);
        cycles(15); check_drained("R3");

        rd_log.delete();
        expect_frame(12, 1216, 10, 13, 8'hC0, 0, 0, "R6", "R6");
        send_frame(13, 8'hC0, 0);
        cycles(15); check_drained("R6");
        check_reads(0, "R7");

        send_frame(8, 8'h01, 0);
        cycles(6);
        check(missed_count == 1, "R8", "missed while idle", missed_count, 1);

        host_write(1, 32'd1536);
        rd_log.delete();
        ctl(32'h4);
        cycles(10);
        check_reads(0, "R8");
        expect_frame(0, 64, 1536, 20, 8'h40, 0, 0, "R7", "R4");
        send_frame(20, 8'h40, 0);
        cycles(15); check_drained("R7");

        host_write(5, 32'd1536);
        ctl(32'h8);
        send_frame(5, 8'h22, 0);
        cycles(6);
        check(missed_count == 2, "R9", "missed while stopped", missed_count, 2);

        for (int f = 0; f < 260; f++) send_frame(1, f, 0);
        cycles(4);
        check(missed_count == 255, "R10", "saturated missed count", missed_count, 255);

        ctl(32'h20);
        cycles(3);
        check(missed_count == 0, "R11", "missed after receive reset", missed_count, 0);
        rd_log.delete();
        ctl(32'h4);
        cycles(10);
        check_reads(0, "R11");

        set_ptr(4);
        rd_log.delete();
        ctl(32'h4);
        cycles(10);
        check_reads(4, "R12");
        expect_frame(4, 448, 1536, 30, 8'h90, 0, 0, "R12", "R12");
        send_frame(30, 8'h90, 0);
        cycles(15); check_drained("R12");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule